// File: doc/BRIEF.md
# Accumulator CPU fetch-execute core

An 8-bit accumulator processor core that reads byte-wide instructions through a synchronous memory port, decodes them and carries them out one at a time. Its programmer-visible state is two 8-bit accumulators (A and B), a 16-bit index register Y, a 16-bit program counter and four condition flags (N, Z, V, C). A and B together form the 16-bit D register, with A as the high byte.

The core runs a small instruction subset:
- clear A and increment B, in inherent mode;
- load A and add to A, in immediate, direct and extended modes;
- store A, in direct and extended modes;
- branch always, in relative mode;
- a swap of D with Y and a decrement of Y, both reached through a prefix byte that opens a second opcode page.

The memory port returns read data one cycle after the address is presented. The core issues each write in a single cycle. Any byte the decoder does not know halts the core and raises an illegal-instruction output. The core reports each finished instruction on a one-cycle retire output, and the register outputs then show that instruction's results.

Top module: `acc_core`

## Requirements
- R1: While rst_ni is low, A, B, Y and flags_o read zero, pc_o reads RESET_PC, and retire_o, illegal_o and mem_we_o are low.
- R2: Every instruction byte is read from the address in the program counter, which then advances by one. After an instruction (other than a branch) retires, pc_o points just past its last byte.
- R3: Opcode 0x4F sets A to 0 and sets the flags to N=0 Z=1 V=0 C=0. Opcode 0x5C sets B to B+1 mod 256 and leaves the flags unchanged.
- R4: Byte 0x18 is a prefix that makes the next byte a second-page opcode. 0x18 0x8F exchanges D ({A,B}, A high) with Y. 0x18 0x09 sets Y to Y-1 mod 65536. Neither changes the flags.
- R5: Load A uses 0x86 (immediate), 0x96 (direct) and 0xB6 (extended). It sets N to bit 7 of the value, sets Z when the value is zero, clears V and leaves C unchanged.
- R6: Add to A uses 0x8B (immediate), 0x9B (direct) and 0xBB (extended). A becomes A+M mod 256. N is bit 7 of the result, Z is set when the result is zero, V is the two's-complement overflow, and C is the carry out of bit 7.
- R7: Store A uses 0x97 (direct) and 0xB7 (extended). It writes A to the effective address, leaves A unchanged, sets N and Z from A, clears V and leaves C unchanged.
- R8: In direct mode the effective address is 0x00 in the high byte and the operand byte in the low byte.
- R9: In extended mode the effective address is the first operand byte (high) followed by the second operand byte (low).
- R10: Opcode 0x20 loads the program counter with the address just past the offset byte plus the sign-extended offset. Offset 0xFE branches to the instruction itself.
- R11: Any other first-page byte, or any second-page byte other than 0x8F and 0x09 (0x18 included), halts the core. illegal_o then stays high, pc_o points just past the offending byte, no write occurs, and no register changes afterwards.
- R12: retire_o is high for one cycle after each completed instruction and is never high together with illegal_o. flags_o carries N, Z, V, C on bits 3, 2, 1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the address |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |
| idx_y_o | output | 16 | Index register Y |
| pc_o | output | 16 | Program counter |
| flags_o | output | 4 | {N,Z,V,C} |
| retire_o | output | 1 | Instruction completed |
| illegal_o | output | 1 | Core halted on an undefined opcode |

## Verification
The hardest situations to reach from the ports are the ones that depend on a particular sequence of bytes:
- a halt on an undefined byte that sits behind the prefix;
- a branch back to itself that never falls through;
- a direct access that must not reach a higher page holding the same low address byte.

Short hand-built programs place these sequences in memory. A bench-side instruction model predicts the register values after every retirement and after the halt. Signed overflow and carry are covered by an add sweep: sixteen spaced values of A, each paired with all 256 operand values.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  localparam logic [DW-1:0] OPC_PREFIX = 8'h18;
  localparam logic [DW-1:0] OPC_CLRA   = 8'h4F;
  localparam logic [DW-1:0] OPC_INCB   = 8'h5C;
  localparam logic [DW-1:0] OPC_LDA_I  = 8'h86;
  localparam logic [DW-1:0] OPC_LDA_D  = 8'h96;
  localparam logic [DW-1:0] OPC_LDA_E  = 8'hB6;
  localparam logic [DW-1:0] OPC_ADD_I  = 8'h8B;
  localparam logic [DW-1:0] OPC_ADD_D  = 8'h9B;
  localparam logic [DW-1:0] OPC_ADD_E  = 8'hBB;
  localparam logic [DW-1:0] OPC_STA_D  = 8'h97;
  localparam logic [DW-1:0] OPC_STA_E  = 8'hB7;
  localparam logic [DW-1:0] OPC_BRA    = 8'h20;
  localparam logic [DW-1:0] OPC2_XCHG  = 8'h8F;
  localparam logic [DW-1:0] OPC2_DECY  = 8'h09;

  typedef enum logic [2:0] {
    OP_CLRA, OP_INCB, OP_XCHG, OP_DECY, OP_LDA, OP_ADD, OP_STA, OP_BRA
  } op_e;

  typedef enum logic [2:0] {M_INH, M_IMM, M_DIR, M_EXT, M_REL} mode_e;

  typedef struct packed {
    logic  legal;
    logic  prefix;
    op_e   op;
    mode_e mode;
  } dec_t;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_OP1, S_OP2, S_MEM, S_HALT} st_e;
endpackage

// File: rtl/acc_core_dec.sv
module acc_core_dec
  import acc_core_pkg::*;
(
  input  logic          page_i,
  input  logic [DW-1:0] byte_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o = '{legal: 1'b1, prefix: 1'b0, op: OP_CLRA, mode: M_INH};
    if (page_i) begin
      unique case (byte_i)
        OPC2_XCHG: dec_o.op = OP_XCHG;
        OPC2_DECY: dec_o.op = OP_DECY;
        default:   dec_o.legal = 1'b0;
      endcase
    end else begin
      unique case (byte_i)
        OPC_PREFIX: dec_o.prefix = 1'b1;
        OPC_CLRA:   dec_o.op = OP_CLRA;
        OPC_INCB:   dec_o.op = OP_INCB;
        OPC_LDA_I:  begin dec_o.op = OP_LDA; dec_o.mode = M_IMM; end
        OPC_LDA_D:  begin dec_o.op = OP_LDA; dec_o.mode = M_DIR; end
        OPC_LDA_E:  begin dec_o.op = OP_LDA; dec_o.mode = M_EXT; end
        OPC_ADD_I:  begin dec_o.op = OP_ADD; dec_o.mode = M_IMM; end
        OPC_ADD_D:  begin dec_o.op = OP_ADD; dec_o.mode = M_DIR; end
        OPC_ADD_E:  begin dec_o.op = OP_ADD; dec_o.mode = M_EXT; end
        OPC_STA_D:  begin dec_o.op = OP_STA; dec_o.mode = M_DIR; end
        OPC_STA_E:  begin dec_o.op = OP_STA; dec_o.mode = M_EXT; end
        OPC_BRA:    begin dec_o.op = OP_BRA; dec_o.mode = M_REL; end
        default:    dec_o.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          add_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic [3:0]    flg_o
);
  logic [DW:0] sum;
  logic        ovf;

  assign sum = {1'b0, a_i} + {1'b0, m_i};
  assign ovf = (a_i[DW-1] == m_i[DW-1]) && (sum[DW-1] != a_i[DW-1]);

  always_comb begin
    if (add_i) begin
      res_o = sum[DW-1:0];
      flg_o = {sum[DW-1], sum[DW-1:0] == '0, ovf, sum[DW]};
    end else begin
      res_o = m_i;
      flg_o = {m_i[DW-1], m_i == '0, 1'b0, c_i};
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] acc_a_o,
  output logic [DW-1:0] acc_b_o,
  output logic [AW-1:0] idx_y_o,
  output logic [AW-1:0] pc_o,
  output logic [3:0]    flags_o,
  output logic          retire_o,
  output logic          illegal_o
);
  st_e           state_q;
  logic          page_q;
  op_e           op_q;
  mode_e         mode_q;
  logic [DW-1:0] hi_q, a_q, b_q;
  logic [AW-1:0] pc_q, y_q;
  logic [3:0]    flg_q;
  logic          done_q, halt_q;

  dec_t          dec;
  logic [DW-1:0] alu_res;
  logic [3:0]    alu_flg;
  logic [3:0]    sta_flg;
  logic [AW-1:0] rel_off;

  acc_core_dec u_dec (
    .page_i(page_q),
    .byte_i(mem_rdata_i),
    .dec_o (dec)
  );

  acc_core_alu u_alu (
    .a_i  (a_q),
    .m_i  (mem_rdata_i),
    .add_i(op_q == OP_ADD),
    .c_i  (flg_q[0]),
    .res_o(alu_res),
    .flg_o(alu_flg)
  );

  assign sta_flg = {a_q[DW-1], a_q == '0, 1'b0, flg_q[0]};
  assign rel_off = {{(AW-DW){mem_rdata_i[DW-1]}}, mem_rdata_i};

  always_comb begin
    mem_addr_o  = pc_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = a_q;
    unique case (state_q)
      S_OP1: if (mode_q == M_DIR) begin
        mem_addr_o = {{(AW-DW){1'b0}}, mem_rdata_i};
        mem_we_o   = (op_q == OP_STA);
      end
      S_OP2: begin
        mem_addr_o = {hi_q, mem_rdata_i};
        mem_we_o   = (op_q == OP_STA);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      page_q  <= 1'b0;
      op_q    <= OP_CLRA;
      mode_q  <= M_INH;
      hi_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      y_q     <= '0;
      pc_q    <= RESET_PC;
      flg_q   <= '0;
      done_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_FETCH: begin
          pc_q    <= pc_q + 1'b1;
          page_q  <= 1'b0;
          state_q <= S_DEC;
        end
        S_DEC: begin
          if (!dec.legal) begin
            halt_q  <= 1'b1;
            state_q <= S_HALT;
          end else if (dec.prefix) begin
            page_q <= 1'b1;  // second opcode byte is being read at pc_q
            pc_q   <= pc_q + 1'b1;
          end else begin
            op_q   <= dec.op;
            mode_q <= dec.mode;
            if (dec.mode == M_INH) begin
              unique case (dec.op)
                OP_CLRA: begin a_q <= '0; flg_q <= 4'b0100; end
                OP_INCB: b_q <= b_q + 1'b1;
                OP_XCHG: begin {a_q, b_q} <= y_q; y_q <= {a_q, b_q}; end
                OP_DECY: y_q <= y_q - 1'b1;
                default: ;
              endcase
              done_q  <= 1'b1;
              state_q <= S_FETCH;
            end else begin
              pc_q    <= pc_q + 1'b1;
              state_q <= S_OP1;
            end
          end
        end
        S_OP1: begin
          unique case (mode_q)
            M_IMM: begin
              a_q <= alu_res; flg_q <= alu_flg;
              done_q <= 1'b1; state_q <= S_FETCH;
            end
            M_REL: begin
              pc_q <= pc_q + rel_off;
              done_q <= 1'b1; state_q <= S_FETCH;
            end
            M_DIR: begin
              if (op_q == OP_STA) begin
                flg_q <= sta_flg; done_q <= 1'b1; state_q <= S_FETCH;
              end else begin
                state_q <= S_MEM;
              end
            end
            default: begin
              hi_q    <= mem_rdata_i;
              pc_q    <= pc_q + 1'b1;
              state_q <= S_OP2;
            end
          endcase
        end
        S_OP2: begin
          if (op_q == OP_STA) begin
            flg_q <= sta_flg; done_q <= 1'b1; state_q <= S_FETCH;
          end else begin
            state_q <= S_MEM;
          end
        end
        S_MEM: begin
          a_q <= alu_res; flg_q <= alu_flg;
          done_q <= 1'b1; state_q <= S_FETCH;
        end
        default: state_q <= S_HALT;
      endcase
    end
  end

  assign acc_a_o   = a_q;
  assign acc_b_o   = b_q;
  assign idx_y_o   = y_q;
  assign pc_o      = pc_q;
  assign flags_o   = flg_q;
  assign retire_o  = done_q;
  assign illegal_o = halt_q;

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH) |=> (pc_q == $past(pc_q) + 16'd1));
  a_r8_dir_page_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_OP1 && mem_we_o) |-> (mem_addr_o[AW-1:DW] == '0));
  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);
  a_r11_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_we_o);
  a_r11_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> ($stable(pc_q) && $stable(a_q) && $stable(b_q) && $stable(y_q) && $stable(flg_q)));
  a_r12_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retire_o && illegal_o));
endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  acc_a, acc_b;
  logic [15:0] idx_y, pc;
  logic [3:0]  flags;
  logic        retire, illegal;

  always #10 clk = ~clk;

  acc_core #(.RESET_PC(16'h0100)) u_acc_core (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .idx_y_o(idx_y), .pc_o(pc),
    .flags_o(flags), .retire_o(retire), .illegal_o(illegal)
  );

  logic [7:0] mem [0:4095];
  logic [7:0] ref_mem [0:4095];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  int errors = 0;
  int checks = 0;
  logic [15:0] wp;

  // bench-side instruction model
  logic [7:0]  m_a, m_b;
  logic [15:0] m_y, m_pc;
  logic [3:0]  m_f;
  logic        m_st;
  logic [15:0] m_ea;
  string       m_tag, m_pc_tag, m_st_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rm(input logic [15:0] a);
    return ref_mem[a[11:0]];
  endfunction

  task automatic put(input logic [7:0] v);
    mem[wp[11:0]] <= v;
    ref_mem[wp[11:0]] = v;
    wp = wp + 16'd1;
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] v);
    mem[a[11:0]] <= v;
    ref_mem[a[11:0]] = v;
  endtask

  task automatic begin_prog();
    rst_ni = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4096; i++) begin
      mem[i] <= 8'h00;
      ref_mem[i] = 8'h00;
    end
    wp = 16'h0100;
    m_a = 0; m_b = 0; m_y = 0; m_pc = 16'h0100; m_f = 0;
  endtask

  task automatic m_load(input logic [7:0] v);
    m_a = v;
    m_f = {v[7], v == 8'h00, 1'b0, m_f[0]};
  endtask

  task automatic m_add(input logic [7:0] v);
    logic [8:0] s;
    s = {1'b0, m_a} + {1'b0, v};
    m_f = {s[7], s[7:0] == 8'h00, (m_a[7] == v[7]) && (s[7] != m_a[7]), s[8]};
    m_a = s[7:0];
  endtask

  task automatic model_step(output bit halted);
    logic [7:0]  op, o1, o2;
    logic [15:0] ea;
    halted = 1'b0; m_st = 1'b0; m_tag = "R11"; m_pc_tag = "R2"; m_st_tag = "R7";
    op = rm(m_pc); m_pc = m_pc + 16'd1;
    if (op == 8'h18) begin
      op = rm(m_pc); m_pc = m_pc + 16'd1;
      m_tag = "R4";
      case (op)
        8'h8F: begin {m_a, m_b, m_y} = {m_y, m_a, m_b}; end
        8'h09: m_y = m_y - 16'd1;
        default: begin halted = 1'b1; m_tag = "R11"; m_pc_tag = "R11"; end
      endcase
      return;
    end
    o1 = rm(m_pc);
    o2 = rm(m_pc + 16'd1);
    ea = (op[5:4] == 2'b01) ? {8'h00, o1} : {o1, o2};
    case (op)
      8'h4F: begin m_a = 0; m_f = 4'b0100; m_tag = "R3"; end
      8'h5C: begin m_b = m_b + 8'd1; m_tag = "R3"; end
      8'h86: begin m_pc += 1; m_load(o1); m_tag = "R5"; end
      8'h96: begin m_pc += 1; m_load(rm(ea)); m_tag = "R8"; end
      8'hB6: begin m_pc += 2; m_load(rm(ea)); m_tag = "R9"; end
      8'h8B: begin m_pc += 1; m_add(o1); m_tag = "R6"; end
      8'h9B: begin m_pc += 1; m_add(rm(ea)); m_tag = "R6"; end
      8'hBB: begin m_pc += 2; m_add(rm(ea)); m_tag = "R6"; end
      8'h97, 8'hB7: begin
        m_pc += (op == 8'h97) ? 16'd1 : 16'd2;
        ref_mem[ea[11:0]] = m_a;
        m_f = {m_a[7], m_a == 8'h00, 1'b0, m_f[0]};
        m_st = 1'b1; m_ea = ea; m_tag = "R7";
        m_st_tag = (op == 8'h97) ? "R8" : "R9";
      end
      8'h20: begin
        m_pc = m_pc + 16'd1 + {{8{o1[7]}}, o1};
        m_tag = "R10"; m_pc_tag = "R10";
      end
      default: begin halted = 1'b1; m_pc_tag = "R11"; end
    endcase
  endtask

  task automatic cmp_regs();
    chk(acc_a === m_a, m_tag, "A", acc_a, m_a);
    chk(acc_b === m_b, m_tag, "B", acc_b, m_b);
    chk(idx_y === m_y, m_tag, "Y", idx_y, m_y);
    chk(flags === m_f, m_tag, "flags NZVC", flags, m_f);
    chk(pc === m_pc, m_pc_tag, "PC", pc, m_pc);
  endtask

  task automatic run_prog(input int max_ret);
    int  nret;
    int  ncyc;
    bit  h;
    nret = 0; ncyc = 0;
    @(negedge clk);
    // R1 reset state
    chk(pc === 16'h0100 && acc_a === 8'h00 && acc_b === 8'h00 && idx_y === 16'h0000,
        "R1", "reset regs", {pc, acc_a, acc_b}, {16'h0100, 16'h0000});
    chk(flags === 4'h0 && !retire && !illegal && !mem_we, "R1", "reset ctl",
        {flags, retire, illegal, mem_we}, 0);
    rst_ni = 1'b1;
    forever begin
      @(negedge clk);
      ncyc++;
      if (retire || illegal) begin
        model_step(h);
        chk(illegal === h, "R11", "halt prediction", illegal, h);
        cmp_regs();
        if (m_st)
          chk(mem[m_ea[11:0]] === rm(m_ea), m_st_tag, "stored byte",
              mem[m_ea[11:0]], rm(m_ea));
        if (illegal) begin
          for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(illegal === 1'b1 && !retire && !mem_we, "R11", "halted ctl",
                {illegal, retire, mem_we}, 3'b100);
            chk(pc === m_pc && acc_a === m_a, "R11", "frozen", {pc, acc_a}, {m_pc, m_a});
          end
          return;
        end
        nret++;
        if (nret == max_ret) return;
      end
      if (ncyc > 40000) begin
        chk(1'b0, "R11", "program did not halt", ncyc, 0);
        return;
      end
    end
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R3 R4: inherent and prefixed instructions
    begin_prog();
    put(8'h86); put(8'h80); put(8'h4F);
    put(8'h5C); put(8'h5C); put(8'h5C);
    put(8'h86); put(8'h7F);
    put(8'h18); put(8'h8F);
    put(8'h18); put(8'h09); put(8'h18); put(8'h09);
    put(8'h18); put(8'h8F); put(8'h5C);
    put(8'h18); put(8'h8F);
    put(8'h4F); put(8'h18); put(8'h09); put(8'h18); put(8'h8F);
    put(8'h5C); put(8'h00);
    run_prog(1000);

    // R6: add sweep with spaced A values against every operand
    for (int av = 0; av < 256; av += 17) begin
      begin_prog();
      for (int m = 0; m < 256; m++) begin
        put(8'h86); put(8'(av)); put(8'h8B); put(8'(m));
      end
      put(8'h00);
      run_prog(2000);
    end

    // R5 R7 R8 R9 R10: memory modes and branches
    begin_prog();
    poke(16'h0040, 8'h91); poke(16'h0540, 8'h22);
    poke(16'h0A12, 8'h7F); poke(16'h0BCD, 8'h01);
    poke(16'h0541, 8'h5A);
    put(8'h96); put(8'h40);
    put(8'h9B); put(8'h40);
    put(8'hBB); put(8'h0A); put(8'h12);
    put(8'h97); put(8'h41);
    put(8'hB6); put(8'h0B); put(8'hCD);
    put(8'hB7); put(8'h0A); put(8'h13);
    put(8'h4F);
    put(8'h97); put(8'h42);
    put(8'h96); put(8'h41);
    put(8'hB6); put(8'h0A); put(8'h13);
    put(8'h20); put(8'h03);
    put(8'h86); put(8'h11);
    put(8'h00);
    put(8'h86); put(8'h22);
    put(8'h20); put(8'hF9);
    run_prog(1000);

    // R10: branch to itself never falls through
    begin_prog();
    put(8'h86); put(8'hF0); put(8'h20); put(8'hFE); put(8'h00);
    run_prog(6);

    // R11: prefix followed by prefix, then undefined store-immediate
    begin_prog();
    put(8'h5C); put(8'h18); put(8'h18); put(8'h5C);
    run_prog(100);
    begin_prog();
    put(8'h86); put(8'h33); put(8'h87); put(8'h44);
    run_prog(100);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule